// File: doc/BRIEF.md
# Radix-4 Complex Butterfly Node

This block is the arithmetic heart of a radix-4 fixed-point FFT or IFFT stage. Each cycle it accepts four complex samples and four complex twiddle factors. Each sample is scaled by its own twiddle, and the four products are then merged through two layers of additions and subtractions into four complex results. One branch of the second layer is rotated by a quarter turn (a multiply by the imaginary unit), which is done by swapping and negating and needs no multiplier.

The arithmetic is combinational. A parameter picks whether the result leaves the block straight away or through one output register that carries a valid flag, for timing closure. Twiddle generation, data reordering between stages and any scaling beyond the fixed truncation belong to the surrounding datapath.

Top module: `r4_butterfly`

## Requirements
- R1: Lane n (n = 0..3) of `din` and of `twid` holds its real part in bits [n*2W + W-1 : n*2W] and its imaginary part in bits [n*2W + 2W-1 : n*2W + W], both signed two's complement; `dout` uses the same layout. Product m_n = twid_n * din_n uses four real multiplies at full precision: re = tr*dr - ti*di, im = tr*di + ti*dr, each arithmetically shifted right by W-1 and truncated to its low W bits.
- R2: The first combining layer forms a0 = m0 + m2, a1 = m0 - m2, a2 = m1 + m3, and a3 = j*(m1 - m3).
- R3: Multiplying a complex value (re, im) by j yields (-im, re), with the negation wrapping in W bits.
- R4: Output lanes are z0 = a0 + a2, z1 = a1 + a3, z2 = a0 - a2, z3 = a1 - a3.
- R5: Every add, subtract and negate wraps modulo 2^W; no saturation.
- R6: With OUT_REG = 0, `dout` equals the result for the present inputs and `out_vld` equals `in_vld`, with no clock involved.
- R7: With OUT_REG = 1, on a rising clock edge with `in_vld` high the result is captured and appears with `out_vld` high one cycle later; on an edge with `in_vld` low, `out_vld` drops to 0 and `dout` keeps its previous value.
- R8: With OUT_REG = 1, while `rst_n` is low, `out_vld` and `dout` are 0.
- R9: All-zero samples give all-zero outputs whatever the twiddles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Marks `din`/`twid` as a valid set |
| din | input | 4*2*W | Four complex samples |
| twid | input | 4*2*W | Four complex twiddle factors |
| out_vld | output | 1 | Marks `dout` as valid |
| dout | output | 4*2*W | Four complex butterfly results |

## Verification
The bench builds two copies side by side at W = 16: one with OUT_REG = 1 and one with OUT_REG = 0, driven by the same inputs. That pairing lets each vector check the registered latency and hold behaviour and the unregistered path against one independent integer model in the same cycle. Corner operands at the most positive and most negative 16-bit values bring the truncation of a product of two full-scale negatives and the wrap of sums into reach, and single-lane stimuli isolate the quarter-turn branch.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  localparam int LANES     = 4;
  localparam int DEF_WIDTH = 16;
endpackage

// File: rtl/bfly_cmul.sv
module bfly_cmul #(
  parameter int W    = 16,
  parameter int FRAC = W - 1
) (
  input  logic [W-1:0] t_re,
  input  logic [W-1:0] t_im,
  input  logic [W-1:0] d_re,
  input  logic [W-1:0] d_im,
  output logic [W-1:0] p_re,
  output logic [W-1:0] p_im
);
  localparam int PW = 2 * W;
  localparam int AW = 2 * W + 1;

  function automatic logic signed [PW-1:0] smul(input logic [W-1:0] a, input logic [W-1:0] b);
    return PW'($signed(a)) * PW'($signed(b));
  endfunction

  function automatic logic [W-1:0] requant(input logic signed [AW-1:0] acc);
    return W'(acc >>> FRAC);
  endfunction

  logic signed [AW-1:0] acc_re, acc_im;

  always_comb begin
    acc_re = AW'(smul(t_re, d_re)) - AW'(smul(t_im, d_im));
    acc_im = AW'(smul(t_re, d_im)) + AW'(smul(t_im, d_re));
    p_re   = requant(acc_re);
    p_im   = requant(acc_im);
  end
endmodule

// File: rtl/bfly_combine.sv
module bfly_combine #(
  parameter int W = 16
) (
  input  logic [3:0][W-1:0] m_re,
  input  logic [3:0][W-1:0] m_im,
  output logic [3:0][W-1:0] z_re,
  output logic [3:0][W-1:0] z_im
);
  logic [3:0][W-1:0] a_re, a_im;
  logic [W-1:0]      diff_re, diff_im;

  function automatic logic [W-1:0] neg_w(input logic [W-1:0] v);
    return W'(-v);
  endfunction

  always_comb begin
    a_re[0] = m_re[0] + m_re[2];
    a_im[0] = m_im[0] + m_im[2];
    a_re[1] = m_re[0] - m_re[2];
    a_im[1] = m_im[0] - m_im[2];
    a_re[2] = m_re[1] + m_re[3];
    a_im[2] = m_im[1] + m_im[3];
    diff_re = m_re[1] - m_re[3];
    diff_im = m_im[1] - m_im[3];
    // quarter turn: (re, im) -> (-im, re)
    a_re[3] = neg_w(diff_im);
    a_im[3] = diff_re;

    z_re[0] = a_re[0] + a_re[2];
    z_im[0] = a_im[0] + a_im[2];
    z_re[1] = a_re[1] + a_re[3];
    z_im[1] = a_im[1] + a_im[3];
    z_re[2] = a_re[0] - a_re[2];
    z_im[2] = a_im[0] - a_im[2];
    z_re[3] = a_re[1] - a_re[3];
    z_im[3] = a_im[1] - a_im[3];
  end
endmodule

// File: rtl/bfly_outstage.sv
module bfly_outstage #(
  parameter int DW      = 128,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          d_vld,
  input  logic [DW-1:0] d,
  output logic          q_vld,
  output logic [DW-1:0] q
);
  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_vld <= 1'b0;
        q     <= '0;
      end else begin
        q_vld <= d_vld;
        if (d_vld) q <= d;
      end
    end
  end else begin : g_pass
    assign q_vld = d_vld;
    assign q     = d;
  end
endmodule

// File: rtl/r4_butterfly.sv
module r4_butterfly
  import bfly_pkg::*;
#(
  parameter int W       = DEF_WIDTH,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_vld,
  input  logic [LANES*2*W-1:0]   din,
  input  logic [LANES*2*W-1:0]   twid,
  output logic                   out_vld,
  output logic [LANES*2*W-1:0]   dout
);
  localparam int LANE_W = 2 * W;
  localparam int BUS_W  = LANES * LANE_W;

  // named internal events for the checker
  logic [3:0][W-1:0] prod_re, prod_im;
  logic [3:0][W-1:0] z_re, z_im;
  logic [BUS_W-1:0]  z_flat;

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    bfly_cmul #(.W(W), .FRAC(W - 1)) u_cmul (
      .t_re (twid[n*LANE_W +: W]),
      .t_im (twid[n*LANE_W + W +: W]),
      .d_re (din[n*LANE_W +: W]),
      .d_im (din[n*LANE_W + W +: W]),
      .p_re (prod_re[n]),
      .p_im (prod_im[n])
    );
    assign z_flat[n*LANE_W +: W]     = z_re[n];
    assign z_flat[n*LANE_W + W +: W] = z_im[n];
  end

  bfly_combine #(.W(W)) u_comb (
    .m_re (prod_re),
    .m_im (prod_im),
    .z_re (z_re),
    .z_im (z_im)
  );

  bfly_outstage #(.DW(BUS_W), .OUT_REG(OUT_REG)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d_vld (in_vld),
    .d     (z_flat),
    .q_vld (out_vld),
    .q     (dout)
  );
endmodule

// File: rtl/r4_butterfly_chk.sv
module r4_butterfly_chk #(
  parameter int W       = 16,
  parameter bit OUT_REG = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_vld,
  input logic [8*W-1:0]      din,
  input logic                out_vld,
  input logic [8*W-1:0]      dout,
  input logic [3:0][W-1:0]   prod_re,
  input logic [3:0][W-1:0]   prod_im,
  input logic [3:0][W-1:0]   z_re,
  input logic [3:0][W-1:0]   z_im,
  input logic [8*W-1:0]      z_flat
);
  logic [W-1:0] all_re, all_im, zs_re, zs_im, m0x4_re, m0x4_im;
  logic         past_ok;

  always_comb begin
    all_re  = prod_re[0] + prod_re[1] + prod_re[2] + prod_re[3];
    all_im  = prod_im[0] + prod_im[1] + prod_im[2] + prod_im[3];
    zs_re   = z_re[0] + z_re[1] + z_re[2] + z_re[3];
    zs_im   = z_im[0] + z_im[1] + z_im[2] + z_im[3];
    m0x4_re = prod_re[0] << 2;
    m0x4_im = prod_im[0] << 2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // z0 gathers every product once (R4)
  p_z0_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (z_re[0] == all_re) && (z_im[0] == all_im));

  // all four outputs sum to four times m0, wrapping (R2, R5)
  p_total_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (zs_re == m0x4_re) && (zs_im == m0x4_im));

  p_zero_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (din == '0) |-> (z_flat == '0));

  if (OUT_REG) begin : g_reg_chk
    p_vld_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (out_vld == $past(in_vld)));
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(in_vld)) |-> (dout == $past(z_flat)));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(in_vld)) |-> $stable(dout));
  end else begin : g_comb_chk
    p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dout == z_flat) && (out_vld == in_vld));
  end
endmodule

bind r4_butterfly r4_butterfly_chk #(.W(W), .OUT_REG(OUT_REG)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_vld  (in_vld),
  .din     (din),
  .out_vld (out_vld),
  .dout    (dout),
  .prod_re (prod_re),
  .prod_im (prod_im),
  .z_re    (z_re),
  .z_im    (z_im),
  .z_flat  (z_flat)
);

// File: tb/tb_r4_butterfly.sv
`timescale 1ns/1ps
module tb_r4_butterfly;
  localparam int W  = 16;
  localparam int BW = 8 * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_vld = 1'b0;
  logic [BW-1:0] din = '0, twid = '0;
  logic          vld_r, vld_c;
  logic [BW-1:0] dout_r, dout_c;
  int            n_vec = 0, n_bad = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  r4_butterfly #(.W(W), .OUT_REG(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .din(din), .twid(twid),
    .out_vld(vld_r), .dout(dout_r));

  r4_butterfly #(.W(W), .OUT_REG(1'b0)) dut_c (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .din(din), .twid(twid),
    .out_vld(vld_c), .dout(dout_c));

  // independent model: integer math, wrapped to 16 bits at each step
  function automatic logic [BW-1:0] model(input logic [BW-1:0] d, input logic [BW-1:0] k);
    int pr[4], pi[4], ar[4], ai[4], zr[4], zi[4];
    longint acc;
    logic [BW-1:0] r;
    for (int n = 0; n < 4; n++) begin
      int xr, xi, tr, ti;
      xr = int'($signed(d[n*32 +: 16]));
      xi = int'($signed(d[n*32+16 +: 16]));
      tr = int'($signed(k[n*32 +: 16]));
      ti = int'($signed(k[n*32+16 +: 16]));
      acc = longint'(tr) * xr - longint'(ti) * xi;
      pr[n] = int'($signed(16'(acc >>> 15)));
      acc = longint'(tr) * xi + longint'(ti) * xr;
      pi[n] = int'($signed(16'(acc >>> 15)));
    end
    ar[0] = pr[0] + pr[2];  ai[0] = pi[0] + pi[2];
    ar[1] = pr[0] - pr[2];  ai[1] = pi[0] - pi[2];
    ar[2] = pr[1] + pr[3];  ai[2] = pi[1] + pi[3];
    ar[3] = -(pi[1] - pi[3]);
    ai[3] = pr[1] - pr[3];
    zr[0] = ar[0] + ar[2];  zi[0] = ai[0] + ai[2];
    zr[1] = ar[1] + ar[3];  zi[1] = ai[1] + ai[3];
    zr[2] = ar[0] - ar[2];  zi[2] = ai[0] - ai[2];
    zr[3] = ar[1] - ar[3];  zi[3] = ai[1] - ai[3];
    for (int n = 0; n < 4; n++) begin
      r[n*32 +: 16]    = 16'(zr[n]);
      r[n*32+16 +: 16] = 16'(zi[n]);
    end
    return r;
  endfunction

  function automatic logic [31:0] cx(input int re, input int im);
    return {16'(im), 16'(re)};
  endfunction

  task automatic check(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive on negedge, sample 5 ns after the following posedge
  task automatic apply(input string req, input logic [BW-1:0] d, input logic [BW-1:0] k);
    logic [BW-1:0] e;
    @(negedge clk);
    din = d; twid = k; in_vld = 1'b1;
    e = model(d, k);
    @(posedge clk); #5;
    check({req, " comb"}, dout_c, e);
    check({req, " reg"},  dout_r, e);
    check({req, " vld"},  {127'd0, vld_r}, {127'd0, 1'b1});
  endtask

  task automatic t_reset();
    repeat (2) @(posedge clk);
    #5;
    check("R8 out_vld in reset", {127'd0, vld_r}, '0);
    check("R8 dout in reset", dout_r, '0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_zero();
    apply("R9 zero samples", '0, {4{cx(12345, -321)}});
  endtask

  task automatic t_lane_walk();
    // one lane at a time with unity-ish twiddle: exercises R1 layout, R2, R3, R4
    for (int n = 0; n < 4; n++) begin
      logic [BW-1:0] d;
      d = '0;
      d[n*32 +: 32] = cx(1000 + n, -700 + n);
      apply($sformatf("R1 R4 lane %0d", n), d, {4{cx(32767, 0)}});
    end
    // lane1 only with j twiddle isolates the quarter-turn path (R3)
    apply("R3 quarter turn", {64'd0, cx(400, 900), 32'd0}, {4{cx(0, 32767)}});
  endtask

  task automatic t_corners();
    apply("R1 full-scale neg*neg", {4{cx(-32768, -32768)}}, {4{cx(-32768, -32768)}});
    apply("R1 max pos", {4{cx(32767, 32767)}}, {4{cx(32767, 32767)}});
    apply("R5 mixed extremes", {cx(32767, -32768), cx(-32768, 32767), cx(32767, 32767), cx(-32768, -32768)},
          {cx(32767, 0), cx(32767, 0), cx(32767, 0), cx(32767, 0)});
  endtask

  task automatic t_wrap();
    // four equal large products: z0 = 4*m overflows and must wrap
    apply("R5 sum wrap", {4{cx(20000, -20000)}}, {4{cx(32767, 0)}});
  endtask

  task automatic t_random();
    void'($urandom(7));
    for (int i = 0; i < 40; i++) begin
      logic [BW-1:0] d, k;
      for (int n = 0; n < 8; n++) begin
        d[n*16 +: 16] = 16'($urandom);
        k[n*16 +: 16] = 16'($urandom);
      end
      apply("R2 R4 random", d, k);
    end
  endtask

  task automatic t_hold();
    logic [BW-1:0] da, db, ka;
    da = {cx(11, 22), cx(-33, 44), cx(55, -66), cx(77, 88)} << 6;
    db = {cx(-9, 8), cx(7, -6), cx(5, 4), cx(-3, 2)} << 8;
    ka = {4{cx(23170, 23170)}};
    apply("R7 load", da, ka);
    @(negedge clk);
    din = db; in_vld = 1'b0;
    @(posedge clk); #5;
    check("R7 hold dout", dout_r, model(da, ka));
    check("R7 vld low", {127'd0, vld_r}, '0);
    check("R6 comb follows", dout_c, model(db, ka));
    check("R6 comb vld", {127'd0, vld_c}, '0);
  endtask

  initial begin
    t_reset();
    t_zero();
    t_lane_walk();
    t_corners();
    t_wrap();
    t_random();
    t_hold();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule